// File: doc/BRIEF.md
# Windowed On-Chip RAM Controller

This block places a 16-bit wide internal RAM inside a 24-bit byte address space. A CPU issues an access in one clock cycle. Each access has an address, a read or write strobe, a size flag that selects byte or word, and 16 bits of write data. When the address falls inside one of two RAM windows and the RAM enable is set, the access is served on chip in that same cycle. Otherwise the block raises an external-select flag, so that the surrounding external bus logic can take the access.

The RAM enable is bit 0 of an 8-bit control register. That register sits at its own byte address, outside both windows, and it is reached through the same bus. A hardware reset sets the enable. The standby input freezes the block: while standby is high, bus accesses are ignored, so the enable and the other register bits keep their values.

The bus has no handshake. Every access completes in the cycle in which it is presented, so the block never applies back-pressure. Read data is valid combinationally in the access cycle. A write takes effect at the clock edge that ends the cycle.

Top module: `winram_ctrl`

## Requirements
- R1: After a hardware reset, the control register reads 0x01. The enable (bit 0) is 1 and bits 7, 5, 4 and 3 are 0.
- R2: Bits 7, 5, 4, 3 and 0 of the control register are writable. Bits 6, 2 and 1 always read 0 and ignore writes. The register is accessed only by byte accesses at CTRL_ADDR (default 0xFFFF39). Its value appears on the lane given by the address parity.
- R3: While the enable is 1, byte and word reads and writes in the main window complete in the access cycle with ext_sel low. The main window is MAIN_LO..MAIN_HI inclusive, default 0xFFB000..0xFFEFBF. Read data is valid in the access cycle. A write is visible to a read in the next cycle.
- R4: While the enable is 1, the top window 0xFFFFC0..0xFFFFFF behaves like the main window and holds separate storage.
- R5: While the enable is 0, any access to either window asserts ext_sel, returns rdata 0 and leaves RAM contents unchanged.
- R6: Any access whose address lies in neither window and is not CTRL_ADDR asserts ext_sel in its cycle. Examples are 0xFFAFFE and 0xFFEFC0.
- R7: Byte lanes are big-endian. A byte at an even address uses rdata/wdata[15:8]. A byte at an odd address uses bits [7:0]. On a byte read, the other lane reads 0.
- R8: A word access at an odd address raises align_err for that cycle only. It performs no RAM or register write, and it returns rdata 0 with ext_sel low.
- R9: While stby is 1, accesses are ignored. ext_sel, align_err and rdata stay 0, and the control register keeps its value.
- R10: A hardware reset sets the enable back to 1 after software has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| stby | input | 1 | Standby: the block ignores the bus and holds its state |
| addr | input | 24 | Byte address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| wdata | input | 16 | Write data: even byte on [15:8], odd byte on [7:0] |
| rdata | output | 16 | Read data, valid in the access cycle |
| ext_sel | output | 1 | The access belongs to the external space |
| align_err | output | 1 | Word access at an odd address was refused |

## Verification
The assertions check on every cycle the routing decisions that depend only on the present inputs and the enable:
- an address in neither window goes external;
- a window address goes external while the enable is clear;
- standby keeps all outputs quiet and the register unchanged;
- an alignment error comes only from an odd word access;
- the unused read lane is 0;
- the fixed-zero register bits stay 0.

Only the bench scenarios can show that stored data survives later accesses:
- data written through one lane and read back through the other size;
- contents untouched across a disabled period and across a refused misaligned write;
- the enable restored by a hardware reset.

// File: rtl/winram_pkg.sv
package winram_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_MAIN = 2'd1,
    RGN_TOP  = 2'd2,
    RGN_CTRL = 2'd3
  } rgn_e;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
endpackage

// File: rtl/winram_decode.sv
module winram_decode
  import winram_pkg::*;
#(
  parameter int            AW         = 24,
  parameter logic [AW-1:0] MAIN_LO    = 24'hFFB000,
  parameter logic [AW-1:0] MAIN_HI    = 24'hFFEFBF,
  parameter logic [AW-1:0] TOP_LO     = 24'hFFFFC0,
  parameter logic [AW-1:0] TOP_HI     = 24'hFFFFFF,
  parameter logic [AW-1:0] CTRL_ADDR  = 24'hFFFF39,
  parameter int            MAIN_WORDS = 8160,
  parameter int            IDX_W      = 13
) (
  input  logic [AW-1:0]    addr,
  input  logic             ram_en,
  input  logic             size_word,
  output rgn_e             rgn,
  output logic [IDX_W-1:0] word_idx
);
  logic in_main, in_top;

  assign in_main = (addr >= MAIN_LO) && (addr <= MAIN_HI);
  assign in_top  = (addr >= TOP_LO)  && (addr <= TOP_HI);

  always_comb begin
    rgn      = RGN_NONE;
    word_idx = '0;
    if (ram_en && in_main) begin
      rgn      = RGN_MAIN;
      word_idx = IDX_W'((addr - MAIN_LO) >> 1);
    end else if (ram_en && in_top) begin
      rgn      = RGN_TOP;
      word_idx = IDX_W'(MAIN_WORDS + ((addr - TOP_LO) >> 1));
    end else if (!size_word && addr == CTRL_ADDR) begin
      rgn      = RGN_CTRL;
    end
  end
endmodule

// File: rtl/winram_ctrlreg.sv
module winram_ctrlreg #(
  parameter logic [7:0] RW_MASK = 8'hB9,
  parameter logic [7:0] RST_VAL = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wbyte & RW_MASK;
  end
endmodule

// File: rtl/winram_store.sv
module winram_store
  import winram_pkg::*;
#(
  parameter int DEPTH = 8192,
  parameter int IDX_W = 13
) (
  input  logic                     clk,
  input  logic [IDX_W-1:0]         idx,
  input  logic [LANES-1:0]         we,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rword
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) cells[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = cells[idx];
  end
endmodule

// File: rtl/winram_ctrl.sv
module winram_ctrl
  import winram_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] MAIN_LO   = 24'hFFB000,
  parameter logic [AW-1:0] MAIN_HI   = 24'hFFEFBF,
  parameter logic [AW-1:0] TOP_LO    = 24'hFFFFC0,
  parameter logic [AW-1:0] TOP_HI    = 24'hFFFFFF,
  parameter logic [AW-1:0] CTRL_ADDR = 24'hFFFF39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          size_word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ext_sel,
  output logic          align_err
);
  localparam int MAIN_WORDS = int'((MAIN_HI - MAIN_LO + 1) >> 1);
  localparam int TOP_WORDS  = int'((TOP_HI - TOP_LO + 1) >> 1);
  localparam int DEPTH      = MAIN_WORDS + TOP_WORDS;
  localparam int IDX_W      = $clog2(DEPTH);

  rgn_e             rgn;
  logic [IDX_W-1:0] word_idx;
  logic [7:0]       ctrl_q;
  logic             access, misalign, ram_hit, ctrl_hit;
  logic [LANES-1:0] lane_sel, ram_we;
  logic [DW-1:0]    rword, lane_mask;
  logic [7:0]       ctrl_wbyte;

  winram_decode #(
    .AW(AW), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI), .TOP_LO(TOP_LO),
    .TOP_HI(TOP_HI), .CTRL_ADDR(CTRL_ADDR), .MAIN_WORDS(MAIN_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .ram_en(ctrl_q[0]), .size_word(size_word),
    .rgn(rgn), .word_idx(word_idx)
  );

  assign access   = (rd | wr) & ~stby;
  assign misalign = access & size_word & addr[0];
  assign ram_hit  = access & ~misalign & (rgn == RGN_MAIN || rgn == RGN_TOP);
  assign ctrl_hit = access & ~misalign & (rgn == RGN_CTRL);

  assign ext_sel   = access & ~misalign & (rgn == RGN_NONE);
  assign align_err = misalign;

  // big-endian lanes: lane 1 = even byte [15:8], lane 0 = odd byte [7:0]
  assign lane_sel  = size_word ? 2'b11 : (addr[0] ? 2'b01 : 2'b10);
  assign ram_we    = {LANES{ram_hit & wr}} & lane_sel;
  assign lane_mask = {{LANE_W{lane_sel[1]}}, {LANE_W{lane_sel[0]}}};

  winram_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .idx(word_idx), .we(ram_we), .wdata(wdata), .rword(rword)
  );

  assign ctrl_wbyte = addr[0] ? wdata[7:0] : wdata[15:8];

  winram_ctrlreg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_hit & wr),
    .wbyte(ctrl_wbyte), .q(ctrl_q)
  );

  always_comb begin
    rdata = '0;
    if (rd && ram_hit)       rdata = rword & lane_mask;
    else if (rd && ctrl_hit) rdata = addr[0] ? {8'h00, ctrl_q} : {ctrl_q, 8'h00};
  end
endmodule

// File: rtl/winram_ctrl_chk.sv
module winram_ctrl_chk #(
  parameter int            AW        = 24,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] MAIN_LO   = 24'hFFB000,
  parameter logic [AW-1:0] MAIN_HI   = 24'hFFEFBF,
  parameter logic [AW-1:0] TOP_LO    = 24'hFFFFC0,
  parameter logic [AW-1:0] TOP_HI    = 24'hFFFFFF,
  parameter logic [AW-1:0] CTRL_ADDR = 24'hFFFF39
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stby,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          wr,
  input logic          size_word,
  input logic [DW-1:0] rdata,
  input logic          ext_sel,
  input logic          align_err,
  input logic [7:0]    ctrl_q
);
  logic live, odd_word, in_main, in_top;
  assign live     = (rd | wr) & ~stby;
  assign odd_word = size_word & addr[0];
  assign in_main  = (addr >= MAIN_LO) && (addr <= MAIN_HI);
  assign in_top   = (addr >= TOP_LO) && (addr <= TOP_HI);

  a_r8_align_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!ext_sel && rdata == '0));
  a_r8_align_cause: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (live && odd_word));
  a_r5_off_external: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !odd_word && !ctrl_q[0] && (in_main || in_top)) |-> (ext_sel && rdata == '0));
  a_r6_outside_external: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !odd_word && !in_main && !in_top && addr != CTRL_ADDR) |-> ext_sel);
  a_r3_inside_local: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctrl_q[0] && (in_main || in_top)) |-> !ext_sel);
  a_r9_stby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (!ext_sel && !align_err && rdata == '0));
  a_r9_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> $stable(ctrl_q));
  a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] == 1'b0 && ctrl_q[2:1] == 2'b00));
  a_r7_even_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !size_word && !addr[0]) |-> rdata[7:0] == 8'h00);
  a_r7_odd_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !size_word && addr[0]) |-> rdata[15:8] == 8'h00);
endmodule

bind winram_ctrl winram_ctrl_chk #(
  .AW(AW), .DW(DW), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI),
  .TOP_LO(TOP_LO), .TOP_HI(TOP_HI), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .addr(addr), .rd(rd), .wr(wr),
  .size_word(size_word), .rdata(rdata), .ext_sel(ext_sel),
  .align_err(align_err), .ctrl_q(ctrl_q)
);

// File: tb/sim_winram_ctrl.sv
`timescale 1ns/1ps
module sim_winram_ctrl;
  localparam logic [23:0] M_LO  = 24'hFFB000;
  localparam logic [23:0] M_HI  = 24'hFFEFBF;
  localparam logic [23:0] T_LO  = 24'hFFFFC0;
  localparam logic [23:0] CTRLA = 24'hFFFF39;

  logic        clk = 0, rst_n = 0, stby = 0, rd = 0, wr = 0, size_word = 0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        ext_sel, align_err;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] bmem [int];
  logic [7:0] creg;

  always #5 clk = ~clk;

  winram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .stby(stby), .addr(addr), .rd(rd), .wr(wr),
    .size_word(size_word), .wdata(wdata), .rdata(rdata),
    .ext_sel(ext_sel), .align_err(align_err)
  );

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rd = 0; wr = 0; stby = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    creg = 8'h01;
  endtask

  // one bus cycle: drive, compare against the model, then update the model
  task automatic acc(string tag, logic [23:0] a, bit r, bit w, bit sz,
                     logic [15:0] d, bit sb);
    logic [15:0] er;
    logic        ee, ea;
    int          ev;
    @(negedge clk);
    addr = a; rd = r; wr = w; size_word = sz; wdata = d; stby = sb;
    #2;
    er = '0; ee = 0; ea = 0;
    ev = int'({a[23:1], 1'b0});
    if (!sb && (r || w)) begin
      if (sz && a[0]) ea = 1;
      else if (!sz && a == CTRLA) begin
        if (r) er = a[0] ? {8'h00, creg} : {creg, 8'h00};
        if (w) creg = (a[0] ? d[7:0] : d[15:8]) & 8'hB9;
      end else if (((a >= M_LO && a <= M_HI) || a >= T_LO) && creg[0]) begin
        if (r) begin
          if (sz)       er = {bmem[ev], bmem[ev+1]};
          else if (a[0]) er = {8'h00, bmem[ev+1]};
          else          er = {bmem[ev], 8'h00};
        end
        if (w) begin
          if (sz || !a[0]) bmem[ev]   = d[15:8];
          if (sz || a[0])  bmem[ev+1] = d[7:0];
        end
      end else ee = 1;
    end
    chk(tag, "rdata", rdata, er);
    chk(tag, "ext_sel", {15'd0, ext_sel}, {15'd0, ee});
    chk(tag, "align_err", {15'd0, align_err}, {15'd0, ea});
  endtask

  initial begin
    do_reset();
    // R1 reset value
    acc("R1", CTRLA, 1, 0, 0, 16'h0, 0);
    // R3 word write/read, R7 byte lanes
    acc("R3", M_LO, 0, 1, 1, 16'h1234, 0);
    acc("R3", M_LO, 1, 0, 1, 16'h0, 0);
    acc("R7", M_LO, 1, 0, 0, 16'h0, 0);
    acc("R7", M_LO + 1, 1, 0, 0, 16'h0, 0);
    acc("R7", M_LO + 1, 0, 1, 0, 16'h55AB, 0);
    acc("R7", M_LO, 1, 0, 1, 16'h0, 0);
    acc("R7", M_LO + 2, 0, 1, 0, 16'hC3FF, 0);
    acc("R7", M_LO + 2, 1, 0, 0, 16'h0, 0);
    // R3 top edge of main window, R6 just outside
    acc("R3", M_HI - 1, 0, 1, 1, 16'hBEEF, 0);
    acc("R3", M_HI - 1, 1, 0, 1, 16'h0, 0);
    acc("R6", M_HI + 1, 1, 0, 1, 16'h0, 0);
    acc("R6", M_LO - 2, 0, 1, 1, 16'h7777, 0);
    acc("R6", 24'h001000, 1, 0, 0, 16'h0, 0);
    // R4 top window
    acc("R4", T_LO, 0, 1, 1, 16'hA5A5, 0);
    acc("R4", 24'hFFFFFE, 0, 1, 1, 16'h0F0E, 0);
    acc("R4", T_LO, 1, 0, 1, 16'h0, 0);
    acc("R4", 24'hFFFFFF, 1, 0, 0, 16'h0, 0);
    acc("R4", M_LO, 1, 0, 1, 16'h0, 0);
    // R8 misaligned word
    acc("R8", M_LO + 1, 0, 1, 1, 16'hFFFF, 0);
    acc("R8", M_LO + 1, 1, 0, 1, 16'h0, 0);
    acc("R8", M_LO, 1, 0, 1, 16'h0, 0);
    // R2 register bits
    acc("R2", CTRLA, 0, 1, 0, 16'h00FF, 0);
    acc("R2", CTRLA, 1, 0, 0, 16'h0, 0);
    acc("R2", CTRLA, 0, 1, 0, 16'h0046, 0);
    acc("R2", CTRLA, 1, 0, 0, 16'h0, 0);
    // R5 disabled: windows go external, contents kept
    acc("R5", M_LO, 1, 0, 1, 16'h0, 0);
    acc("R5", M_LO, 0, 1, 1, 16'hDEAD, 0);
    acc("R5", T_LO, 0, 1, 0, 16'h9900, 0);
    acc("R5", CTRLA, 0, 1, 0, 16'h0001, 0);
    acc("R5", M_LO, 1, 0, 1, 16'h0, 0);
    acc("R5", T_LO, 1, 0, 1, 16'h0, 0);
    // R9 standby
    acc("R9", CTRLA, 0, 1, 0, 16'h0000, 1);
    acc("R9", M_LO, 0, 1, 1, 16'h1111, 1);
    acc("R9", M_LO + 1, 1, 0, 1, 16'h0, 1);
    acc("R9", 24'h000000, 1, 0, 0, 16'h0, 1);
    acc("R9", CTRLA, 1, 0, 0, 16'h0, 0);
    acc("R9", M_LO, 1, 0, 1, 16'h0, 0);
    // R10 reset restores the enable
    acc("R10", CTRLA, 0, 1, 0, 16'h00B8, 0);
    acc("R10", M_LO, 1, 0, 1, 16'h0, 0);
    do_reset();
    acc("R10", CTRLA, 1, 0, 0, 16'h0, 0);
    acc("R10", M_HI - 1, 0, 1, 1, 16'h4242, 0);
    acc("R10", M_HI - 1, 1, 0, 1, 16'h0, 0);
    @(negedge clk);
    rd = 0; wr = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule